// File: doc/BRIEF.md
# Time-Multiplexed Complex FIR Filter

This block filters a stream of complex samples, an in-phase rail and a quadrature rail, with a finite impulse response whose length is set at run time. It uses one multiply-accumulate per rail and steps through the taps one per clock. The clock runs many times faster than the sample rate, so a full convolution fits between two input samples. The block keeps no taps and no history in its own registers. The coefficient words sit in an external synchronous RAM that both rails share. Each rail keeps its past samples in its own external synchronous RAM, used as a circular buffer. The filter drives all three memories through plain address, select, write-enable and data ports.

When a valid input pair arrives, the sequencer writes it into both history memories at the current write pointer. It then reads N history/coefficient pairs and accumulates their products. Finally it scales the sum down by the coefficient fraction width, clips it to the sample width and presents one valid output pair. Two bank bits pick one of four coefficient sets. A bypass flag returns each input unchanged, and a synchronous active-low clear wipes the history by writing zeros across the whole depth.

Top module: `cfir_tdm`

## Requirements
- R1: After reset, and after every cycle with `clr_n` low, the block writes zero to all 512 addresses of both history memories. `out_vld` stays low until that sweep ends, and an input offered during the sweep is dropped and yields no output.
- R2: Outside bypass, the output for the n-th sample since the last clear is sat((sum over k = 0..N-1 of c[k]·x[n-k]) >>> FRAC). Samples from before the clear count as zero, and FRAC is 8 by default.
- R3: Both rails use the same coefficient word for each tap but separate histories. A stimulus on one rail never shows up on the other.
- R4: Each accepted input, filtered or bypassed, produces exactly one cycle of `out_vld`.
- R5: With `byp` high, `out_i`/`out_q` equal the accepted input on the following cycle, and the history memories are not written.
- R6: Tap k of bank b is read from coefficient address {b, k}. The 2-bit bank forms the top bits and the 7-bit tap index forms the bottom bits.
- R7: The tap count `ntaps` may be any value from 0 to 127. With 0 the output is zero.
- R8: The scaled sum is clipped to the 9-bit signed range: results above 255 give 255 and results below -256 give -256.
- R9: A clear issued between samples discards all earlier history. The next filtered output depends only on samples accepted after the clear.
- R10: Read data are used the cycle after the address. Every coefficient read pairs with a history read at the same time, and a history write never overlaps a coefficient read.
- R11: The history write pointer advances by one per filtered sample and wraps at 512 entries, so the convolution stays correct past the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low history clear |
| byp | input | 1 | Pass samples through unfiltered |
| bank | input | 2 | Coefficient bank select |
| ntaps | input | 7 | Number of taps used (0 to 127) |
| in_vld | input | 1 | Input pair valid |
| in_i | input | 9 | Input in-phase sample, signed |
| in_q | input | 9 | Input quadrature sample, signed |
| out_vld | output | 1 | Output pair valid, one cycle per input |
| out_i | output | 9 | Output in-phase sample, signed |
| out_q | output | 9 | Output quadrature sample, signed |
| cf_addr | output | 9 | Coefficient memory address |
| cf_cs | output | 1 | Coefficient memory select (read) |
| cf_rdata | input | 18 | Coefficient memory read data, signed |
| di_addr | output | 9 | In-phase history address |
| di_wdata | output | 9 | In-phase history write data |
| di_cs | output | 1 | In-phase history select |
| di_we | output | 1 | In-phase history write enable |
| di_rdata | input | 9 | In-phase history read data |
| dq_addr | output | 9 | Quadrature history address |
| dq_wdata | output | 9 | Quadrature history write data |
| dq_cs | output | 1 | Quadrature history select |
| dq_we | output | 1 | Quadrature history write enable |
| dq_rdata | input | 9 | Quadrature history read data |

## Verification
The filter is first driven with a unit impulse on one rail and a 4-3-2-1 tap set. This shows tap order, the time alignment of the history and the absence of cross-rail leakage. Pseudo-random pairs then run through every bank and through tap counts from 0 to 9 and 127, which separates bank addressing and tap-count handling from the basic MAC path. Full-scale constant inputs in both signs probe the clipping. A run of 530 samples goes past the history wrap. Bypass samples placed between filtered ones show that bypass leaves the history untouched. Clears issued both before the first sample and mid-stream show that no stale sample can reach a later output.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

  typedef enum logic [2:0] {
    S_CLR,
    S_IDLE,
    S_RUN,
    S_FLUSH,
    S_OUT
  } seq_st_t;

endpackage

// File: rtl/cfir_seq.sv
module cfir_seq
  import cfir_pkg::*;
#(
  parameter  int NW = 7,
  parameter  int BW = 2,
  localparam int AW = BW + NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          byp,
  input  logic [BW-1:0] bank,
  input  logic [NW-1:0] ntaps,
  input  logic          in_vld,
  output logic [AW-1:0] dl_addr,
  output logic          dl_cs,
  output logic          dl_we,
  output logic          dl_zero,
  output logic [AW-1:0] cf_addr,
  output logic          cf_cs,
  output logic          acc_clr,
  output logic          mac_en,
  output logic          emit,
  output logic          take,
  output logic          out_vld
);

  seq_st_t       st, st_n;
  logic [AW-1:0] cnt, cnt_n, wp, wp_n;
  logic          mac_en_q, vld_q, take_c, emit_c, tap_last;

  assign tap_last = ({1'b0, cnt[NW-1:0]} + (NW+1)'(1)) >= {1'b0, ntaps};
  assign cf_addr  = {bank, cnt[NW-1:0]};

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    wp_n    = wp;
    dl_addr = wp;
    dl_cs   = 1'b0;
    dl_we   = 1'b0;
    dl_zero = 1'b0;
    cf_cs   = 1'b0;
    acc_clr = 1'b0;
    take_c  = 1'b0;
    emit_c  = 1'b0;
    unique case (st)
      S_CLR: begin
        dl_cs   = 1'b1;
        dl_we   = 1'b1;
        dl_zero = 1'b1;
        dl_addr = cnt;
        cnt_n   = cnt + AW'(1);
        if (&cnt) begin
          st_n  = S_IDLE;
          cnt_n = '0;
          wp_n  = '0;
        end
      end
      S_IDLE: begin
        if (in_vld) begin
          if (byp) begin
            take_c = 1'b1;
          end else begin
            dl_cs   = 1'b1;
            dl_we   = 1'b1;
            acc_clr = 1'b1;
            cnt_n   = '0;
            st_n    = (ntaps == '0) ? S_OUT : S_RUN;
          end
        end
      end
      S_RUN: begin
        dl_cs   = 1'b1;
        cf_cs   = 1'b1;
        dl_addr = wp - cnt;
        if (tap_last) st_n = S_FLUSH;
        else          cnt_n = cnt + AW'(1);
      end
      S_FLUSH: st_n = S_OUT;
      S_OUT: begin
        emit_c = 1'b1;
        wp_n   = wp + AW'(1);
        st_n   = S_IDLE;
      end
      default: st_n = S_CLR;
    endcase
    if (!clr_n) begin
      st_n   = S_CLR;
      cnt_n  = '0;
      take_c = 1'b0;
      emit_c = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_CLR;
      cnt      <= '0;
      wp       <= '0;
      mac_en_q <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      wp       <= wp_n;
      mac_en_q <= (st == S_RUN);
      vld_q    <= take_c | emit_c;
    end
  end

  assign mac_en  = mac_en_q;
  assign emit    = emit_c;
  assign take    = take_c;
  assign out_vld = vld_q;

  // R1
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !out_vld);

  // R10
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cf_cs |-> (dl_cs && !dl_we));

  // R10
  mac_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en |-> $past(cf_cs));

  // R4
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($past(st) == S_OUT || $past(take_c)));

endmodule

// File: rtl/cfir_rail.sv
module cfir_rail #(
  parameter int DW   = 9,
  parameter int CW   = 18,
  parameter int NW   = 7,
  parameter int FRAC = 8,
  localparam int PW   = DW + CW,
  localparam int ACCW = PW + NW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_clr,
  input  logic                 mac_en,
  input  logic                 emit,
  input  logic                 take,
  input  logic                 dl_zero,
  input  logic signed [DW-1:0] smp_in,
  input  logic signed [CW-1:0] coef,
  input  logic signed [DW-1:0] hist,
  output logic        [DW-1:0] wdata,
  output logic        [DW-1:0] dout
);

  logic signed [ACCW-1:0] acc, acc_n, shifted, hi_lim, lo_lim;
  logic signed [PW-1:0]   prod;
  logic        [DW-1:0]   dout_n, sat_v;

  assign wdata   = dl_zero ? '0 : smp_in;
  assign prod    = hist * coef;
  assign shifted = acc >>> FRAC;
  assign hi_lim  = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  assign lo_lim  = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  assign sat_v   = (shifted > hi_lim) ? hi_lim[DW-1:0] :
                   (shifted < lo_lim) ? lo_lim[DW-1:0] : shifted[DW-1:0];

  always_comb begin
    acc_n  = acc;
    dout_n = dout;
    if (acc_clr)     acc_n = '0;
    else if (mac_en) acc_n = acc + {{NW{prod[PW-1]}}, prod};
    if (take)        dout_n = smp_in;
    else if (emit)   dout_n = sat_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      dout <= '0;
    end else begin
      acc  <= acc_n;
      dout <= dout_n;
    end
  end

  // R5
  byp_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> dout == $past(smp_in));

  // R8
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && shifted > hi_lim) |=> dout == {1'b0, {(DW-1){1'b1}}});

  // R8
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && shifted < lo_lim) |=> dout == {1'b1, {(DW-1){1'b0}}});

endmodule

// File: rtl/cfir_tdm.sv
module cfir_tdm #(
  parameter  int DW   = 9,
  parameter  int CW   = 18,
  parameter  int NW   = 7,
  parameter  int BW   = 2,
  parameter  int FRAC = 8,
  localparam int AW   = BW + NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          byp,
  input  logic [BW-1:0] bank,
  input  logic [NW-1:0] ntaps,
  input  logic          in_vld,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  output logic          out_vld,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  output logic [AW-1:0] cf_addr,
  output logic          cf_cs,
  input  logic [CW-1:0] cf_rdata,
  output logic [AW-1:0] di_addr,
  output logic [DW-1:0] di_wdata,
  output logic          di_cs,
  output logic          di_we,
  input  logic [DW-1:0] di_rdata,
  output logic [AW-1:0] dq_addr,
  output logic [DW-1:0] dq_wdata,
  output logic          dq_cs,
  output logic          dq_we,
  input  logic [DW-1:0] dq_rdata
);

  logic [1:0]          rsync;
  logic                rst_q_n;
  logic [AW-1:0]       dl_addr;
  logic                dl_cs, dl_we, dl_zero, acc_clr, mac_en, emit, take;
  logic [1:0][DW-1:0]  smp_a, hist_a, wdat_a, dout_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q_n = rsync[1];

  cfir_seq #(.NW(NW), .BW(BW)) i_seq (
    .clk(clk), .rst_n(rst_q_n), .clr_n(clr_n), .byp(byp), .bank(bank),
    .ntaps(ntaps), .in_vld(in_vld), .dl_addr(dl_addr), .dl_cs(dl_cs),
    .dl_we(dl_we), .dl_zero(dl_zero), .cf_addr(cf_addr), .cf_cs(cf_cs),
    .acc_clr(acc_clr), .mac_en(mac_en), .emit(emit), .take(take),
    .out_vld(out_vld)
  );

  assign smp_a[0]  = in_i;
  assign smp_a[1]  = in_q;
  assign hist_a[0] = di_rdata;
  assign hist_a[1] = dq_rdata;

  for (genvar g = 0; g < 2; g++) begin : g_rail
    cfir_rail #(.DW(DW), .CW(CW), .NW(NW), .FRAC(FRAC)) i_rail (
      .clk(clk), .rst_n(rst_q_n), .acc_clr(acc_clr), .mac_en(mac_en),
      .emit(emit), .take(take), .dl_zero(dl_zero), .smp_in(smp_a[g]),
      .coef(cf_rdata), .hist(hist_a[g]), .wdata(wdat_a[g]),
      .dout(dout_a[g])
    );
  end

  assign out_i    = dout_a[0];
  assign out_q    = dout_a[1];
  assign di_addr  = dl_addr;
  assign dq_addr  = dl_addr;
  assign di_cs    = dl_cs;
  assign dq_cs    = dl_cs;
  assign di_we    = dl_we;
  assign dq_we    = dl_we;
  assign di_wdata = wdat_a[0];
  assign dq_wdata = wdat_a[1];

endmodule

// File: tb/test_cfir_tdm.sv
module test_cfir_tdm;
  localparam int DW = 9, CW = 18, NW = 7, BW = 2, FRAC = 8, AW = 9;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, clr_n, byp, in_vld;
  logic [BW-1:0] bank;
  logic [NW-1:0] ntaps;
  logic [DW-1:0] in_i, in_q, out_i, out_q;
  logic          out_vld, cf_cs, di_cs, di_we, dq_cs, dq_we;
  logic [AW-1:0] cf_addr, di_addr, dq_addr;
  logic [CW-1:0] cf_rdata;
  logic [DW-1:0] di_wdata, dq_wdata, di_rdata, dq_rdata;

  cfir_tdm #(.DW(DW), .CW(CW), .NW(NW), .BW(BW), .FRAC(FRAC)) i_cfir_tdm (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .byp(byp), .bank(bank),
    .ntaps(ntaps), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q),
    .cf_addr(cf_addr), .cf_cs(cf_cs), .cf_rdata(cf_rdata),
    .di_addr(di_addr), .di_wdata(di_wdata), .di_cs(di_cs), .di_we(di_we),
    .di_rdata(di_rdata), .dq_addr(dq_addr), .dq_wdata(dq_wdata),
    .dq_cs(dq_cs), .dq_we(dq_we), .dq_rdata(dq_rdata)
  );

  // synchronous single-port memories
  logic [CW-1:0] cmem [0:DEPTH-1];
  logic [DW-1:0] imem [0:DEPTH-1];
  logic [DW-1:0] qmem [0:DEPTH-1];
  always @(posedge clk) begin
    if (cf_cs) cf_rdata <= cmem[cf_addr];
    if (di_cs) begin
      if (di_we) imem[di_addr] <= di_wdata;
      else       di_rdata <= imem[di_addr];
    end
    if (dq_cs) begin
      if (dq_we) qmem[dq_addr] <= dq_wdata;
      else       dq_rdata <= qmem[dq_addr];
    end
  end

  int total = 0, bad = 0, vcnt = 0, exp_outs = 0, proto_bad = 0, nsmp = 0;
  int cf [0:DEPTH-1];
  int hxi [0:4095];
  int hxq [0:4095];
  int unsigned seed = 32'h1234_5678;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (out_vld === 1'b1) vcnt++;
    if (cf_cs === 1'b1 && (di_we === 1'b1 || dq_we === 1'b1)) proto_bad++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd9();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[23:15]) - 256;
  endfunction

  function automatic int ref_out(input bit rail, input int n);
    longint acc = 0;
    for (int k = 0; k < int'(ntaps); k++) begin
      if (n - k >= 0)
        acc += longint'(cf[int'(bank) * 128 + k]) *
               longint'(rail ? hxq[(n - k) % 4096] : hxi[(n - k) % 4096]);
    end
    acc = acc >>> FRAC;
    if (acc > 255) acc = 255;
    if (acc < -256) acc = -256;
    return int'(acc);
  endfunction

  task automatic send(input int xi, input int xq, output int yi,
                      output int yq, output bit got);
    yi = 0; yq = 0; got = 1'b0;
    @(negedge clk);
    in_i = DW'(xi); in_q = DW'(xq); in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    for (int w = 0; w < 400 && !got; w++) begin
      if (out_vld === 1'b1) begin
        got = 1'b1;
        yi = int'($signed(out_i));
        yq = int'($signed(out_q));
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic filt(input int xi, input int xq, input string tag,
                      output int yi);
    int yq, ei, eq;
    bit got;
    hxi[nsmp % 4096] = xi;
    hxq[nsmp % 4096] = xq;
    ei = ref_out(1'b0, nsmp);
    eq = ref_out(1'b1, nsmp);
    send(xi, xq, yi, yq, got);
    exp_outs++;
    chk({tag, " R4 out_vld"}, longint'(got), 1);
    chk({tag, " I"}, yi, ei);
    chk({tag, " Q"}, yq, eq);
    nsmp++;
  endtask

  task automatic do_clear_wait();
    int v0;
    @(negedge clk); clr_n = 1'b0;
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    v0 = vcnt;
    repeat (100) @(negedge clk);
    in_i = DW'(100); in_q = DW'(-100); in_vld = 1'b1;
    @(negedge clk); in_vld = 1'b0;
    repeat (500) @(negedge clk);
    chk("R9 no output during clear sweep", vcnt - v0, 0);
    nsmp = 0;
  endtask

  initial begin
    int y, nz, yi, yq;
    bit got;
    int lit [0:7] = '{4, 3, 2, 1, 4, 3, 2, 1};
    rst_n = 1'b0; clr_n = 1'b1; byp = 1'b0; in_vld = 1'b0;
    in_i = '0; in_q = '0; bank = '0; ntaps = 7'd4;
    for (int a = 0; a < DEPTH; a++) begin
      cf[a] = (((a * 53) % 97) - 48) * 16;
      imem[a] = DW'(77); qmem[a] = DW'(-77);
    end
    for (int k = 0; k < 4; k++) cf[k] = (4 - k) << FRAC;
    for (int a = 0; a < DEPTH; a++) cmem[a] = CW'(cf[a]);
    repeat (3) @(negedge clk);
    chk("R1 out_vld low in reset", longint'(out_vld), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    in_i = DW'(5); in_q = DW'(5); in_vld = 1'b1;
    @(negedge clk); in_vld = 1'b0;
    repeat (600) @(negedge clk);
    chk("R1 input during sweep dropped", vcnt, 0);
    nz = 0;
    for (int a = 0; a < DEPTH; a++) if (imem[a] != '0 || qmem[a] != '0) nz++;
    chk("R1 history memories zeroed", nz, 0);

    // impulse on I: R2 R3
    for (int n = 0; n < 8; n++) begin
      filt((n % 4 == 0) ? 1 : 0, 0, "R2 R3 impulse I", y);
      chk("R2 impulse literal", y, lit[n]);
    end
    // impulse on Q
    for (int n = 0; n < 8; n++) filt(0, (n % 4 == 0) ? 1 : 0, "R3 impulse Q", y);

    // banks: R6
    for (int b = 0; b < 4; b++) begin
      bank = BW'(b); ntaps = 7'd5;
      for (int n = 0; n < 6; n++) filt(rnd9(), rnd9(), "R6 bank", y);
    end

    // tap counts: R7
    for (int t = 0; t < 10; t++) begin
      ntaps = NW'(t); bank = BW'(t % 4);
      for (int n = 0; n < 3; n++) filt(rnd9(), rnd9(), "R7 ntaps", y);
    end
    ntaps = 7'd127; bank = 2'd1;
    for (int n = 0; n < 3; n++) filt(rnd9(), rnd9(), "R7 ntaps 127", y);

    // saturation: R8
    bank = '0; ntaps = 7'd4;
    for (int n = 0; n < 4; n++) filt(255, -256, "R8 clip", y);
    chk("R8 clip high", y, 255);
    for (int n = 0; n < 4; n++) filt(-256, 255, "R8 clip", y);
    chk("R8 clip low", y, -256);

    // bypass: R5
    byp = 1'b1;
    for (int n = 0; n < 3; n++) begin
      int xi, xq;
      xi = rnd9(); xq = rnd9();
      send(xi, xq, yi, yq, got);
      exp_outs++;
      chk("R5 bypass valid", longint'(got), 1);
      chk("R5 bypass I", yi, xi);
      chk("R5 bypass Q", yq, xq);
    end
    byp = 1'b0;
    filt(3, -7, "R5 history untouched by bypass", y);

    // wrap of the write pointer: R11
    bank = 2'd2; ntaps = 7'd3;
    for (int n = 0; n < 530; n++) filt(rnd9(), rnd9(), "R11 wrap", y);

    // clear mid-stream: R9
    do_clear_wait();
    bank = '0; ntaps = 7'd4;
    for (int n = 0; n < 4; n++) begin
      filt(n == 0 ? 2 : 0, 0, "R9 after clear", y);
      chk("R9 fresh history", y, 2 * (4 - n));
    end

    repeat (20) @(negedge clk);
    chk("R4 one output per input", vcnt, exp_outs);
    chk("R10 no write during coefficient read", proto_bad, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule